// File: doc/BRIEF.md
# Two-Plane Scanline Cursor Overlay

This block lays a 32x32 hardware cursor over a stream of display pixels. Software loads two planes of 32 row words each through a simple register port. One plane is the mask, which says which cursor pixels are opaque. The other plane holds the color bits, which pick between two overlay colors. Software also writes a packed X/Y position word. The palette logic supplies the two overlay colors as plain inputs. The block does not store them.

Each pixel arrives with its x and y coordinates and a valid flag. When a pixel falls inside the visible part of the cursor and its mask bit is set, one overlay color replaces it. Every other pixel passes through unchanged. The output stream is one register stage behind the input, and coordinates and valid travel with the data. The register port also holds a general-purpose 32-bit control word, and reads of that word always show one fixed status bit set.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor X position is 0xF000, the Y position is 0, and all mask words, color-bit words and the control word are zero. With an active width of 640 the cursor is therefore off-screen and no pixel is replaced.
- R2: A write to offsets 0x900..0x97C loads mask row (offset-0x900)/4. A write to offsets 0x980..0x9FC loads color-bit row (offset-0x980)/4. Other rows are left unchanged.
- R3: Bit 31 of a row word covers the leftmost cursor column (x equal to cursor X). Column c uses bit 31-c.
- R4: A covered pixel whose mask bit is 1 takes overlay color A when its color bit is 1, and overlay color B when its color bit is 0. A pixel whose mask bit is 0 keeps its input value.
- R5: A line is affected only when cursor Y <= y <= cursor Y + 31.
- R6: A pixel is covered only when cursor X is below the active width, cursor X <= x < cursor X + 32, and x < active width. This clips the cursor to min(32, width - cursor X) columns.
- R7: A write to offset 0x8FC sets cursor X from data bits 31:16 and cursor Y from data bits 15:0.
- R8: A read of offset 0x818 returns the stored control word with bit 25 forced to 1. A read of any other offset, including the cursor registers, returns 0. A write to 0x818 stores all 32 bits.
- R9: Output valid, x, y and data appear exactly one clock after the matching input. Output valid is 0 in a cycle that follows an input cycle without valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| active_width | input | 16 | Number of visible pixels per line |
| color_a | input | PIX_W | Overlay color used when mask=1 and bit=1 |
| color_b | input | PIX_W | Overlay color used when mask=1 and bit=0 |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 16 | Input pixel column |
| pix_y_i | input | 16 | Input pixel line |
| pix_data_i | input | PIX_W | Input pixel value |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_x_o | output | 16 | Output pixel column |
| pix_y_o | output | 16 | Output pixel line |
| pix_data_o | output | PIX_W | Output pixel value after the overlay |

## Verification
The embedded assertions check several properties on every cycle. They check that the output lags the input by exactly one stage, for valid and coordinates. They check that each output pixel equals color A, color B or the delayed input. They check that a cursor hit never lies beyond the active width or above cursor Y, and that the control word always reads back with bit 25 set. Other behaviours show up only in the directed scenarios: which row a given offset lands in, the MSB-first column order, the choice between A, B and transparent, the exact edges of the 32-line and 32-column window, the width clip, and the parked reset position.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int REG_AW   = 12;
  localparam int REG_DW   = 32;
  localparam int CUR_DIM  = 32;
  localparam int ROW_W    = $clog2(CUR_DIM);
  localparam int COORD_W  = 16;

  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h818;
  localparam logic [REG_AW-1:0] OFS_POS  = 12'h8FC;
  localparam logic [REG_AW-1:0] OFS_MASK = 12'h900;
  localparam logic [REG_AW-1:0] OFS_BITS = 12'h980;

  localparam logic [COORD_W-1:0] PARK_X  = 16'hF000;
  localparam int                 CTRL_FIXED_BIT = 25;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } cur_pos_t;
endpackage

// File: rtl/cursor_rst_sync.sv
module cursor_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [ROW_W-1:0]  row_sel,
  output logic [REG_DW-1:0] mask_word,
  output logic [REG_DW-1:0] bits_word,
  output cur_pos_t          pos
);
  localparam int ROW_LSB  = 2;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  logic [REG_DW-1:0] mask_q [CUR_DIM];
  logic [REG_DW-1:0] bits_q [CUR_DIM];
  logic [REG_DW-1:0] ctrl_q;
  cur_pos_t          pos_q;

  logic               in_mask_bank, in_bits_bank;
  logic [ROW_W-1:0]   wr_row;
  logic [CUR_DIM-1:0] mask_we, bits_we;
  logic               pos_we, ctrl_we;

  always_comb begin
    in_mask_bank = addr[REG_AW-1:BANK_LSB] == OFS_MASK[REG_AW-1:BANK_LSB];
    in_bits_bank = addr[REG_AW-1:BANK_LSB] == OFS_BITS[REG_AW-1:BANK_LSB];
    wr_row       = addr[BANK_LSB-1:ROW_LSB];
    pos_we       = wr_en && (addr == OFS_POS);
    ctrl_we      = wr_en && (addr == OFS_CTRL);
    for (int r = 0; r < CUR_DIM; r++) begin
      mask_we[r] = wr_en && in_mask_bank && (wr_row == ROW_W'(r));
      bits_we[r] = wr_en && in_bits_bank && (wr_row == ROW_W'(r));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < CUR_DIM; r++) begin
        mask_q[r] <= '0;
        bits_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < CUR_DIM; r++) begin
        if (mask_we[r]) mask_q[r] <= wdata;
        if (bits_we[r]) bits_q[r] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q.x <= PARK_X;
      pos_q.y <= '0;
    end else if (pos_we) begin
      pos_q.x <= wdata[31:16];
      pos_q.y <= wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL) begin
      rdata = ctrl_q;
      rdata[CTRL_FIXED_BIT] = 1'b1;
    end
  end

  assign mask_word = mask_q[row_sel];
  assign bits_word = bits_q[row_sel];
  assign pos       = pos_q;

  // R8: the control word never reads back with its status bit clear
  a_r8_ctrl_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CTRL) |-> rdata[CTRL_FIXED_BIT]);

  // R7: a position write is visible on the next cycle
  a_r7_pos_update: assert property (@(posedge clk) disable iff (!rst_n)
    pos_we |=> (pos.x == $past(wdata[31:16]) && pos.y == $past(wdata[15:0])));
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] active_width,
  input  cur_pos_t           pos,
  output logic [ROW_W-1:0]   row_sel,
  output logic [ROW_W-1:0]   bit_sel,
  output logic               hit
);
  localparam logic [COORD_W:0] SPAN = (COORD_W+1)'(CUR_DIM);

  logic [COORD_W:0]   y_end, x_end;
  logic               line_on, col_on;
  logic [COORD_W-1:0] dy, dx;

  always_comb begin
    y_end   = {1'b0, pos.y} + SPAN;
    x_end   = {1'b0, pos.x} + SPAN;
    line_on = (pix_y >= pos.y) && ({1'b0, pix_y} < y_end) && (pos.x < active_width);
    col_on  = (pix_x >= pos.x) && ({1'b0, pix_x} < x_end) && (pix_x < active_width);
    dy      = pix_y - pos.y;
    dx      = pix_x - pos.x;
    row_sel = dy[ROW_W-1:0];
    bit_sel = ~dx[ROW_W-1:0];
    hit     = line_on && col_on;
  end

  // R6: a covered pixel never lies at or beyond the active width
  a_r6_hit_inside_width: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hit) |-> (pix_x < active_width));

  // R5: a covered pixel never lies above the cursor's first line
  a_r5_hit_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hit) |-> (pix_y >= pos.y));
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [PIX_W-1:0]   pix_data_i,
  input  logic               hit,
  input  logic [REG_DW-1:0]  mask_word,
  input  logic [REG_DW-1:0]  bits_word,
  input  logic [ROW_W-1:0]   bit_sel,
  input  logic [PIX_W-1:0]   color_a,
  input  logic [PIX_W-1:0]   color_b,
  output logic               pix_valid_o,
  output logic [COORD_W-1:0] pix_x_o,
  output logic [COORD_W-1:0] pix_y_o,
  output logic [PIX_W-1:0]   pix_data_o
);
  logic             opaque, pick_a;
  logic [PIX_W-1:0] data_nxt;

  logic               valid_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [PIX_W-1:0]   data_q;

  always_comb begin
    opaque   = hit && mask_word[bit_sel];
    pick_a   = bits_word[bit_sel];
    data_nxt = pix_data_i;
    if (opaque) data_nxt = pick_a ? color_a : color_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= pix_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      data_q <= '0;
    end else if (pix_valid_i) begin
      x_q    <= pix_x_i;
      y_q    <= pix_y_i;
      data_q <= data_nxt;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_x_o     = x_q;
  assign pix_y_o     = y_q;
  assign pix_data_o  = data_q;

  // R9: valid and coordinates trail the input by one clock
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> pix_valid_o);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_i |=> !pix_valid_o);
  a_r9_coords_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> (pix_x_o == $past(pix_x_i) && pix_y_o == $past(pix_y_i)));

  // R4: an output pixel is one of the two overlay colors or the input value
  a_r4_data_choice: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> (pix_data_o == $past(color_a) || pix_data_o == $past(color_b) ||
                     pix_data_o == $past(pix_data_i)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic [COORD_W-1:0] active_width,
  input  logic [PIX_W-1:0]   color_a,
  input  logic [PIX_W-1:0]   color_b,
  input  logic               pix_valid_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [PIX_W-1:0]   pix_data_i,
  output logic               pix_valid_o,
  output logic [COORD_W-1:0] pix_x_o,
  output logic [COORD_W-1:0] pix_y_o,
  output logic [PIX_W-1:0]   pix_data_o
);
  logic              rst_int_n;
  cur_pos_t          pos;
  logic [ROW_W-1:0]  row_sel, bit_sel;
  logic [REG_DW-1:0] mask_word, bits_word;
  logic              hit;

  cursor_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cursor_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .row_sel   (row_sel),
    .mask_word (mask_word),
    .bits_word (bits_word),
    .pos       (pos)
  );

  cursor_hit u_hit (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pix_valid    (pix_valid_i),
    .pix_x        (pix_x_i),
    .pix_y        (pix_y_i),
    .active_width (active_width),
    .pos          (pos),
    .row_sel      (row_sel),
    .bit_sel      (bit_sel),
    .hit          (hit)
  );

  cursor_mixer #(.PIX_W(PIX_W)) u_mix (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pix_valid_i (pix_valid_i),
    .pix_x_i     (pix_x_i),
    .pix_y_i     (pix_y_i),
    .pix_data_i  (pix_data_i),
    .hit         (hit),
    .mask_word   (mask_word),
    .bits_word   (bits_word),
    .bit_sel     (bit_sel),
    .color_a     (color_a),
    .color_b     (color_b),
    .pix_valid_o (pix_valid_o),
    .pix_x_o     (pix_x_o),
    .pix_y_o     (pix_y_o),
    .pix_data_o  (pix_data_o)
  );
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PIX_W = 24;
  localparam logic [PIX_W-1:0] CA = 24'hAAAAAA;
  localparam logic [PIX_W-1:0] CB = 24'h555555;
  localparam logic [PIX_W-1:0] PD = 24'h123456;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] active_width;
  logic [PIX_W-1:0] color_a, color_b;
  logic pix_valid_i;
  logic [15:0] pix_x_i, pix_y_i;
  logic [PIX_W-1:0] pix_data_i;
  logic pix_valid_o;
  logic [15:0] pix_x_o, pix_y_o;
  logic [PIX_W-1:0] pix_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cursor_overlay #(.PIX_W(PIX_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active_width(active_width),
    .color_a(color_a), .color_b(color_b), .pix_valid_i(pix_valid_i),
    .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .pix_data_i(pix_data_i),
    .pix_valid_o(pix_valid_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
    .pix_data_o(pix_data_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  task automatic pix(input logic [15:0] x, input logic [15:0] y,
                     input logic [PIX_W-1:0] exp, input string tag);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_x_i = x; pix_y_i = y; pix_data_i = PD;
    @(negedge clk);
    pix_valid_i = 1'b0;
    check({tag, " data"}, 32'(pix_data_o), 32'(exp));
    check("R9 valid", 32'(pix_valid_o), 32'd1);
    check("R9 coords", {pix_x_o, pix_y_o}, {x, y});
  endtask

  task automatic t_reset;
    check("R1 valid after reset", 32'(pix_valid_o), 32'd0);
    rd_check(12'h818, 32'h0200_0000, "R1 R8 ctrl reset value");
    active_width = 16'd640;
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h980, 32'hFFFF_FFFF);
    pix(16'd0, 16'd0, PD, "R1 parked cursor leaves x=0");
    active_width = 16'hFFFF;
    pix(16'hF000, 16'd0, CA, "R1 park X is 0xF000");
    pix(16'hEFFF, 16'd0, PD, "R1 left of parked X");
    active_width = 16'd640;
    @(negedge clk);
    check("R9 idle gives no valid", 32'(pix_valid_o), 32'd0);
  endtask

  task automatic t_columns;
    wr(12'h8FC, {16'd100, 16'd50});
    wr(12'h900, 32'hC000_0001);
    wr(12'h980, 32'h8000_0000);
    pix(16'd100, 16'd50, CA, "R3 R4 R7 leftmost column color A");
    pix(16'd101, 16'd50, CB, "R3 R4 second column color B");
    pix(16'd102, 16'd50, PD, "R4 mask 0 transparent");
    pix(16'd131, 16'd50, CB, "R3 rightmost column bit 0");
    pix(16'd132, 16'd50, PD, "R6 column 32 outside");
    pix(16'd99,  16'd50, PD, "R6 left of cursor");
  endtask

  task automatic t_rows;
    wr(12'h97C, 32'h8000_0000);
    wr(12'h9FC, 32'h8000_0000);
    wr(12'h914, 32'h8000_0000);
    wr(12'h994, 32'h0000_0000);
    wr(12'h984, 32'hFFFF_FFFF);
    pix(16'd100, 16'd81, CA, "R2 R5 last row 31");
    pix(16'd100, 16'd55, CB, "R2 row 5");
    pix(16'd100, 16'd82, PD, "R5 line below window");
    pix(16'd100, 16'd49, PD, "R5 line above window");
    pix(16'd100, 16'd51, PD, "R4 bits set mask clear");
    pix(16'd100, 16'd50, CA, "R2 row 0 kept");
  endtask

  task automatic t_clip;
    wr(12'h8FC, {16'd620, 16'd0});
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h980, 32'h0000_0000);
    active_width = 16'd640;
    pix(16'd639, 16'd0, CB, "R6 last visible column");
    pix(16'd640, 16'd0, PD, "R6 clipped at width");
    active_width = 16'd800;
    pix(16'd645, 16'd0, CB, "R6 wider line not clipped");
    pix(16'd651, 16'd0, CB, "R6 column 31");
    pix(16'd652, 16'd0, PD, "R6 column 32");
    active_width = 16'd640;
  endtask

  task automatic t_ctrl;
    wr(12'h818, 32'h0000_00A5);
    rd_check(12'h818, 32'h0200_00A5, "R8 ctrl with fixed bit");
    wr(12'h818, 32'hFFFF_FFFF);
    rd_check(12'h818, 32'hFFFF_FFFF, "R8 ctrl all ones");
    rd_check(12'h900, 32'h0, "R8 mask offset reads 0");
    rd_check(12'h8FC, 32'h0, "R8 position reads 0");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    active_width = 16'd640; color_a = CA; color_b = CB;
    pix_valid_i = 1'b0; pix_x_i = '0; pix_y_i = '0; pix_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_columns();
    t_rows();
    t_clip();
    t_ctrl();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule